// File: doc/BRIEF.md
# Layered Barrel Rotator

This combinational block rotates a data word to the left by a binary amount from zero up to one less than the word width. A bit pushed out past the most significant position comes back in at position zero, so no bit is lost and no fill value is needed. The block has no clock and no state. The output follows the data and amount inputs within the same cycle.

The word width is a power-of-two parameter and defaults to 32. There is one selector layer for each bit of the amount. Layer k either passes its input straight through or rotates it by 2^k positions, and every layer uses only two-input selectors. Rotations pile up from the least significant amount bit to the most significant one. This keeps the fan-in of every cell at two, at the cost of log2(width) selector levels in series. An output bit is never built as one wide selector.

Top module: `barrel_rot`

## Requirements
- R1: When the amount is zero, the output equals the data input bit for bit.
- R2: For every amount s, output bit i equals data bit (i - s) mod WIDTH. This is a left rotation, with bit 0 as the least significant position.
- R3: With amount 1, the most significant data bit appears at output bit 0.
- R4: The output always holds the same number of ones as the data input.
- R5: An amount with only bit k set rotates by exactly 2^k positions. An amount with several bits set rotates by the sum of their weights.
- R6: With amount WIDTH-1, data bit 0 appears at the most significant output bit. The whole word reads as a rotation right by one position.
- R7: The same module gives the R2 mapping at WIDTH=4, where the amount is 2 bits wide, and at WIDTH=32, where it is 5 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | WIDTH | Word to be rotated |
| amt_i | input | log2(WIDTH) | Left rotation amount, unsigned |
| data_o | output | WIDTH | Rotated word |

## Verification
The block is purely combinational. A faulty layer shows at data_o in the same cycle that the amount reaches it, with no delay to wait for. A layer with the wrong step, or with a stuck or inverted select, corrupts only the amounts that have that layer's bit set. The single-bit amount sweeps therefore point to the faulty layer directly, and the exhaustive pass at width 4 covers every path through both layers. A wrong wrap index moves bits off the word's ends, which shows first at the amount-1 and amount-(WIDTH-1) corner cases.

// File: rtl/barrel_rot_pkg.sv
package barrel_rot_pkg;

  // True when v is a non-zero power of two.
  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // Rotation distance contributed by layer k.
  function automatic int unsigned layer_step(input int unsigned k);
    return 32'd1 << k;
  endfunction

  // Source position feeding output position i after a left rotation by step.
  function automatic int unsigned wrap_src(input int unsigned i,
                                           input int unsigned step,
                                           input int unsigned w);
    return (i + w - (step % w)) % w;
  endfunction

endpackage

// File: rtl/rot_mux2.sv
module rot_mux2 (
  input  logic keep_i,
  input  logic move_i,
  input  logic sel_i,
  output logic y_o
);
  // Two-input selector cell: passes keep_i, or move_i when sel_i is set.
  assign y_o = sel_i ? move_i : keep_i;
endmodule

// File: rtl/rot_layer.sv
module rot_layer #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned STEP  = 1
) (
  input  logic [WIDTH-1:0] lay_in,
  input  logic             lay_sel,
  output logic [WIDTH-1:0] lay_out
);
  import barrel_rot_pkg::*;

  // One column of two-input cells. Each cell picks either its own bit or
  // the bit STEP places below it, wrapping around the top of the word.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam int unsigned SRC = wrap_src(i, STEP, WIDTH);
    rot_mux2 u_cell (
      .keep_i (lay_in[i]),
      .move_i (lay_in[SRC]),
      .sel_i  (lay_sel),
      .y_o    (lay_out[i])
    );
  end
endmodule

// File: rtl/barrel_rot.sv
module barrel_rot #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [WIDTH-1:0] data_o
);
  import barrel_rot_pkg::*;

  localparam bit WIDTH_OK = is_pow2(WIDTH) && (WIDTH >= 2);

  // Layers are chained from the least significant amount bit upward.
  for (genvar k = 0; k < AMT_W; k++) begin : g_layer
    logic [WIDTH-1:0] lay_in;
    logic [WIDTH-1:0] lay_out;

    if (k == 0) begin : g_head
      assign lay_in = data_i;
    end else begin : g_chain
      assign lay_in = g_layer[k-1].lay_out;
    end

    rot_layer #(
      .WIDTH (WIDTH),
      .STEP  (layer_step(k))
    ) u_layer (
      .lay_in  (lay_in),
      .lay_sel (amt_i[k]),
      .lay_out (lay_out)
    );
  end

  if (WIDTH_OK) begin : g_out
    assign data_o = g_layer[AMT_W-1].lay_out;
  end else begin : g_bad_width
    assign data_o = data_i;
  end
endmodule

// File: rtl/barrel_rot_chk.sv
module barrel_rot_chk #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AMT_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] data_i,
  input logic [AMT_W-1:0] amt_i,
  input logic [WIDTH-1:0] data_o
);
  // Reference model: shift a doubled copy of the word and keep its upper half.
  logic [2*WIDTH-1:0] dbl_w;
  logic [WIDTH-1:0]   ref_w;

  assign dbl_w = {data_i, data_i} << amt_i;
  assign ref_w = dbl_w[2*WIDTH-1:WIDTH];

  always_comb begin
    assert_zero_amount_passes_R1: assert ((amt_i != '0) || (data_o == data_i))
      else $error("R1: amount zero changed data");
    assert_left_rotate_R2: assert (data_o == ref_w)
      else $error("R2: output is not a left rotation of data");
    assert_top_bit_wraps_R3: assert ((amt_i != AMT_W'(1)) || (data_o[0] == data_i[WIDTH-1]))
      else $error("R3: top bit did not wrap to bit 0");
    assert_ones_preserved_R4: assert ($countones(data_o) == $countones(data_i))
      else $error("R4: number of ones changed");
    assert_full_turn_minus_one_R6: assert ((amt_i != AMT_W'(WIDTH-1)) || (data_o[WIDTH-1] == data_i[0]))
      else $error("R6: bit 0 did not reach the top");
  end
endmodule

bind barrel_rot barrel_rot_chk #(.WIDTH(WIDTH)) u_barrel_rot_chk (
  .data_i (data_i),
  .amt_i  (amt_i),
  .data_o (data_o)
);

// File: tb/test_barrel_rot.sv
`timescale 1ns/1ps
module test_barrel_rot;

  logic clk;
  logic rst_n;

  logic [31:0] d32;
  logic [4:0]  s32;
  logic [31:0] y32;
  logic [3:0]  d4;
  logic [1:0]  s4;
  logic [3:0]  y4;

  barrel_rot #(.WIDTH(32)) i_barrel_rot (
    .data_i (d32), .amt_i (s32), .data_o (y32)
  );

  barrel_rot #(.WIDTH(4)) i_barrel_rot_w4 (
    .data_i (d4), .amt_i (s4), .data_o (y4)
  );

  typedef struct {
    logic [31:0] exp;
    bit          narrow;
    string       req;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Expected left rotation, computed bit by bit from R2.
  function automatic logic [31:0] exp_rot(input logic [31:0] d, input int s, input int w);
    logic [31:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = d[(i - s + w) % w];
    return r;
  endfunction

  task automatic drive32(input logic [31:0] d, input logic [4:0] s, input string req);
    sb_item_t it;
    @(negedge clk);
    d32 = d; s32 = s;
    it.exp = exp_rot(d, int'(s), 32); it.narrow = 1'b0; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic drive4(input logic [3:0] d, input logic [1:0] s, input string req);
    sb_item_t it;
    @(negedge clk);
    d4 = d; s4 = s;
    it.exp = exp_rot({28'd0, d}, int'(s), 4); it.narrow = 1'b1; it.req = req;
    sb_q.push_back(it);
  endtask

  // Monitor: compares the oldest expected item against the output.
  always @(posedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      sb_item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = it.narrow ? {28'd0, y4} : y32;
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  initial begin
    d32 = '0; s32 = '0; d4 = '0; s4 = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // Idle state after reset: zero in, zero out (R1).
    drive32(32'h0, 5'd0, "R1");
    drive4(4'h0, 2'd0, "R1");

    // R1: amount zero leaves data unchanged.
    drive32(32'hDEAD_BEEF, 5'd0, "R1");
    drive32(32'h8000_0001, 5'd0, "R1");

    // R7 and R2: exhaustive at width 4.
    for (int d = 0; d < 16; d++)
      for (int s = 0; s < 4; s++)
        drive4(4'(d), 2'(s), "R7");

    // R3: top bit wraps to bit 0.
    drive32(32'h8000_0000, 5'd1, "R3");
    drive4(4'b1000, 2'd1, "R3");

    // R6: amount WIDTH-1.
    drive32(32'h0000_0001, 5'd31, "R6");
    drive32(32'h1234_5679, 5'd31, "R6");

    // R5: single-bit amounts isolate each layer, then combinations.
    for (int k = 0; k < 5; k++) begin
      drive32(32'h0000_0001, 5'(1 << k), "R5");
      drive32(32'hA5C3_0F71, 5'(1 << k), "R5");
    end
    drive32(32'hC000_0003, 5'd21, "R5");
    drive32(32'h0F0F_00FF, 5'd10, "R5");

    // R4: ones are preserved for dense and sparse patterns.
    drive32(32'hFFFF_FFFE, 5'd17, "R4");
    drive32(32'h5555_5555, 5'd3,  "R4");

    // R2: random words and amounts at width 32.
    for (int n = 0; n < 200; n++)
      drive32($urandom, 5'($urandom_range(0, 31)), "R2");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule